// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the control core of one DMA channel. Software-prepared settings arrive as a 32-bit configuration word, a source start address, a destination start address and a byte count. A start pulse asks the channel to begin. Before it accepts a job, the channel checks the configuration and the address alignment. If the job is accepted, the channel issues one source/destination address pair per transfer unit on a valid/ready handshake. It also reports the unit size in bytes with each pair.

Each address moves by the step after every accepted transfer. It can go up, go down, or hold. A hold setting always overrides the direction setting for that side. In the two directions that involve a peripheral, each transfer waits for a peripheral request. Memory-to-memory jobs run back to back. When the count is used up, the channel gives a one-cycle completion pulse and returns to idle. A job that is refused never starts and raises an error flag instead.

Top module: `dma_addr_seq`

## Requirements
- R1: Configuration bits 7:6 choose the direction. 00 is memory to memory, 01 is memory to peripheral and 10 is peripheral to memory. The code 11 refuses the start.
- R2: Configuration bits 9:8 choose the unit: 00 is 1 byte, 01 is 2 bytes and 10 is 4 bytes. The code 11 refuses the start. `xfer_size_o` gives the step in bytes while the job runs.
- R3: Configuration bit 10 makes the step 16 bytes. It is only accepted when bits 9:8 are 10; with any other unit code it refuses the start.
- R4: When an address is neither held nor set to decrement, it increases by the step after each accepted transfer. Bit 12 set makes the source decrease by the step, and bit 11 set does the same for the destination. Addresses wrap modulo 2^AW.
- R5: Bit 14 set holds the source address for the whole job, and bit 13 set holds the destination address. Each hold bit overrides that side's decrement bit.
- R6: A start is refused when either start address is not a multiple of the step.
- R7: A start is refused when the byte count is zero or is not a multiple of the step.
- R8: A refused start sets `err_o`, and the channel does not become busy or assert `xfer_valid_o`. The next accepted start clears `err_o`. Configuration bits 5:0 and 31:15 have no effect.
- R9: In the two peripheral directions, `xfer_valid_o` is high only in cycles where `preq_i` is high.
- R10: In memory-to-memory jobs, `xfer_valid_o` stays high in every busy cycle regardless of `preq_i`. A new pair is issued on each cycle in which `xfer_ready_i` is high.
- R11: Each accepted transfer reduces the remaining count by the step. One cycle after the last accepted transfer, `done_o` is high for exactly one cycle and `busy_o` is low. A job is exactly count/step transfers long.
- R12: A start pulse while busy is ignored. The running job's addresses, size and length do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start_i | input | 1 | Start request, sampled while idle |
| cfg_i | input | 32 | Channel configuration word |
| src_i | input | AW | Source start address |
| dst_i | input | AW | Destination start address |
| len_i | input | CW | Total byte count |
| preq_i | input | 1 | Peripheral request |
| xfer_ready_i | input | 1 | Downstream accepts the current pair |
| xfer_valid_o | output | 1 | Address pair is valid |
| xfer_src_o | output | AW | Source address of the current unit |
| xfer_dst_o | output | AW | Destination address of the current unit |
| xfer_size_o | output | 5 | Unit size in bytes (1, 2, 4 or 16) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion pulse |
| err_o | output | 1 | Last start request was refused |

## Verification
An address register in the wrong mode shows up as a wrong `xfer_src_o` or `xfer_dst_o` on the second pair of the job. That is one accepted transfer after start. A wrong remaining count shows up at the end of the job, where `done_o` arrives early or late compared with count/step handshakes. A fault in the decode or the alignment checks shows up in the cycle right after the start edge: `err_o` and `busy_o` are checked there against the bench's own acceptance rule. The bench mixes random jobs with directed cases for the refusal rules, hold priority and address wrap below zero, and compares every pair and every handshake cycle with its own model.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int unsigned DIR_LSB   = 6;
  localparam int unsigned UNIT_LSB  = 8;
  localparam int unsigned BLK_BIT   = 10;
  localparam int unsigned DDEC_BIT  = 11;
  localparam int unsigned SDEC_BIT  = 12;
  localparam int unsigned DHOLD_BIT = 13;
  localparam int unsigned SHOLD_BIT = 14;
  localparam int unsigned STEP_W    = 5;

  typedef enum logic [1:0] {
    DIR_M2M = 2'b00,
    DIR_M2P = 2'b01,
    DIR_P2M = 2'b10,
    DIR_RSV = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    ADJ_INC  = 2'b00,
    ADJ_DEC  = 2'b01,
    ADJ_HOLD = 2'b10
  } adj_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } chan_state_e;

  typedef struct packed {
    dir_e              dir;
    logic [STEP_W-1:0] step;
    adj_e              src_adj;
    adj_e              dst_adj;
    logic              bad;
  } chan_cfg_t;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_seq_pkg::*;
(
  input  logic [31:0] cfg_i,
  output chan_cfg_t   dec_o
);

  logic [1:0] unit_code;
  logic       blk_mode;
  logic [STEP_W-1:0] base_step;

  assign unit_code = cfg_i[UNIT_LSB +: 2];
  assign blk_mode  = cfg_i[BLK_BIT];

  always_comb begin
    base_step = STEP_W'(1) << unit_code;
    dec_o.dir  = dir_e'(cfg_i[DIR_LSB +: 2]);
    dec_o.step = blk_mode ? (base_step << 2) : base_step;
    // hold beats the direction bit on each side
    if (cfg_i[SHOLD_BIT])      dec_o.src_adj = ADJ_HOLD;
    else if (cfg_i[SDEC_BIT])  dec_o.src_adj = ADJ_DEC;
    else                       dec_o.src_adj = ADJ_INC;
    if (cfg_i[DHOLD_BIT])      dec_o.dst_adj = ADJ_HOLD;
    else if (cfg_i[DDEC_BIT])  dec_o.dst_adj = ADJ_DEC;
    else                       dec_o.dst_adj = ADJ_INC;
    dec_o.bad = (cfg_i[DIR_LSB +: 2] == 2'b11) ||
                (unit_code == 2'b11) ||
                (blk_mode && (unit_code != 2'b10));
  end

endmodule

// File: rtl/dma_job_check.sv
module dma_job_check
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  chan_cfg_t       dec_i,
  input  logic [AW-1:0]   src_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [CW-1:0]   len_i,
  output logic            ok_o
);

  logic [STEP_W-1:0] low_mask;
  logic              src_mis;
  logic              dst_mis;
  logic              len_bad;

  always_comb begin
    low_mask = dec_i.step - STEP_W'(1);
    src_mis  = |(src_i[STEP_W-1:0] & low_mask);
    dst_mis  = |(dst_i[STEP_W-1:0] & low_mask);
    len_bad  = (len_i == '0) || (|(len_i[STEP_W-1:0] & low_mask));
    ok_o     = !dec_i.bad && !src_mis && !dst_mis && !len_bad;
  end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [AW-1:0]     load_addr_i,
  input  adj_e              load_adj_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              adv_i,
  output logic [AW-1:0]     addr_o
);

  localparam int unsigned PADW = AW - STEP_W;

  logic [AW-1:0] addr_q, addr_d;
  adj_e          adj_q,  adj_d;
  logic          addr_en;
  logic [AW-1:0] step_ext;

  assign step_ext = {{PADW{1'b0}}, step_i};
  assign addr_en  = load_i || adv_i;

  always_comb begin
    adj_d  = load_i ? load_adj_i : adj_q;
    addr_d = addr_q;
    if (load_i) begin
      addr_d = load_addr_i;
    end else if (adv_i) begin
      case (adj_q)
        ADJ_INC: addr_d = addr_q + step_ext;
        ADJ_DEC: addr_d = addr_q - step_ext;
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      adj_q  <= ADJ_INC;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (load_i)  adj_q  <= adj_d;
    end
  end

  assign addr_o = addr_q;

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && adj_q == ADJ_HOLD) |=> (addr_o == $past(addr_o)));

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       cfg_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [CW-1:0]     len_i,
  input  logic              preq_i,
  input  logic              xfer_ready_i,
  output logic              xfer_valid_o,
  output logic [AW-1:0]     xfer_src_o,
  output logic [AW-1:0]     xfer_dst_o,
  output logic [STEP_W-1:0] xfer_size_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int unsigned CPAD = CW - STEP_W;
  localparam int unsigned NSIDE = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  chan_cfg_t dec;
  logic      job_ok;

  dma_cfg_decode u_dec (
    .cfg_i (cfg_i),
    .dec_o (dec)
  );

  dma_job_check #(.AW(AW), .CW(CW)) u_chk (
    .dec_i (dec),
    .src_i (src_i),
    .dst_i (dst_i),
    .len_i (len_i),
    .ok_o  (job_ok)
  );

  chan_state_e       state_q, state_d;
  logic [CW-1:0]     rem_q,   rem_d;
  logic [STEP_W-1:0] step_q;
  dir_e              dir_q;
  logic              err_q,   err_d;
  logic              done_q,  done_d;

  logic take_start, launch, accept, last_xfer;
  logic rem_en, cfg_en, err_en;
  logic [CW-1:0] step_cnt;

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign launch     = take_start && job_ok;
  assign xfer_valid_o = (state_q == ST_RUN) && ((dir_q == DIR_M2M) || preq_i);
  assign accept     = xfer_valid_o && xfer_ready_i;
  assign step_cnt   = {{CPAD{1'b0}}, step_q};
  assign last_xfer  = accept && (rem_q == step_cnt);

  assign rem_en = launch || accept;
  assign cfg_en = launch;
  assign err_en = take_start;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch)    state_d = ST_RUN;
      ST_RUN:  if (last_xfer) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
    rem_d  = launch ? len_i : (rem_q - step_cnt);
    err_d  = !job_ok;
    done_d = last_xfer;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      step_q  <= STEP_W'(1);
      dir_q   <= DIR_M2M;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (rem_en) rem_q <= rem_d;
      if (cfg_en) begin
        step_q <= dec.step;
        dir_q  <= dec.dir;
      end
      if (err_en) err_q <= err_d;
    end
  end

  // one address unit per side: 0 = source, 1 = destination
  logic [NSIDE-1:0][AW-1:0] side_start;
  adj_e                     side_adj [NSIDE];
  logic [NSIDE-1:0][AW-1:0] side_addr;

  assign side_start[0] = src_i;
  assign side_start[1] = dst_i;
  assign side_adj[0]   = dec.src_adj;
  assign side_adj[1]   = dec.dst_adj;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_addr_unit #(.AW(AW)) u_addr (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .load_i      (launch),
      .load_addr_i (side_start[s]),
      .load_adj_i  (side_adj[s]),
      .step_i      (step_q),
      .adv_i       (accept),
      .addr_o      (side_addr[s])
    );
  end

  assign xfer_src_o  = side_addr[0];
  assign xfer_dst_o  = side_addr[1];
  assign xfer_size_o = step_q;
  assign busy_o      = (state_q == ST_RUN);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    done_o |-> !busy_o);

  // R11
  rem_cover_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy_o |-> (rem_q != '0) && (rem_q >= step_cnt));

  // R6
  src_align_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    xfer_valid_o |-> ((xfer_src_o[STEP_W-1:0] & (xfer_size_o - STEP_W'(1))) == '0));

  // R6
  dst_align_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    xfer_valid_o |-> ((xfer_dst_o[STEP_W-1:0] & (xfer_size_o - STEP_W'(1))) == '0));

  // R8
  err_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(err_o && busy_o));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy_o && start_i) |=> (xfer_size_o == $past(xfer_size_o)));

  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy_o |-> $onehot0(xfer_size_o) && (xfer_size_o != 5'd8));

endmodule

// File: tb/test_dma_addr_seq.sv
`timescale 1ns/1ps
module test_dma_addr_seq;

  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [31:0]   cfg_i;
  logic [AW-1:0] src_i, dst_i;
  logic [CW-1:0] len_i;
  logic          preq_i, xfer_ready_i;
  logic          xfer_valid_o;
  logic [AW-1:0] xfer_src_o, xfer_dst_o;
  logic [4:0]    xfer_size_o;
  logic          busy_o, done_o, err_o;

  int checks = 0;
  int failures = 0;

  dma_addr_seq #(.AW(AW), .CW(CW)) i_dma_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
    .src_i(src_i), .dst_i(dst_i), .len_i(len_i), .preq_i(preq_i),
    .xfer_ready_i(xfer_ready_i), .xfer_valid_o(xfer_valid_o),
    .xfer_src_o(xfer_src_o), .xfer_dst_o(xfer_dst_o),
    .xfer_size_o(xfer_size_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int step_of(input logic [31:0] c);
    int s;
    s = 1 << c[9:8];
    if (c[10]) s = s << 2;
    return s;
  endfunction

  function automatic bit job_ok(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d, input logic [15:0] l);
    int st;
    if (c[7:6] == 2'b11) return 0;
    if (c[9:8] == 2'b11) return 0;
    if (c[10] && c[9:8] != 2'b10) return 0;
    st = step_of(c);
    if ((s % st) != 0 || (d % st) != 0) return 0;
    if (l == 0 || (l % st) != 0) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] next_addr(input logic [31:0] a, input bit hold, input bit dec, input int st);
    if (hold) return a;
    if (dec)  return a - 32'(st);
    return a + 32'(st);
  endfunction

  task automatic run_job(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] l, input int rdy_pct, input int req_pct);
    bit ok;
    int st, n_left, guard;
    logic [31:0] es, ed;
    bit m2m, exp_v, acc;
    ok = job_ok(c, s, d, l);
    @(negedge clk);
    cfg_i = c; src_i = s; dst_i = d; len_i = l; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(err_o == !ok, ok ? "R8 err clear" : "R1/R2/R3/R6/R7/R8 refused start sets err", 32'(err_o), 32'(!ok));
    chk(busy_o == ok, "R8 busy after start", 32'(busy_o), 32'(ok));
    if (!ok) begin
      chk(xfer_valid_o == 1'b0, "R8 no valid after refusal", 32'(xfer_valid_o), 0);
      return;
    end
    st = step_of(c);
    chk(xfer_size_o == 5'(st), "R2/R3 size", 32'(xfer_size_o), 32'(st));
    es = s; ed = d; n_left = l / st; m2m = (c[7:6] == 2'b00); guard = 0;
    while (n_left > 0 && guard < 2000) begin
      guard++;
      xfer_ready_i = (($urandom % 100) < rdy_pct);
      preq_i       = (($urandom % 100) < req_pct);
      start_i      = ($urandom % 4) == 0;      // R12 junk start while busy
      cfg_i = $urandom; src_i = $urandom; dst_i = $urandom; len_i = 16'($urandom);
      #1;
      exp_v = m2m || preq_i;
      chk(xfer_valid_o == exp_v, m2m ? "R10 m2m valid" : "R9 periph valid", 32'(xfer_valid_o), 32'(exp_v));
      chk(busy_o == 1'b1, "R11 busy during job", 32'(busy_o), 1);
      if (xfer_valid_o) begin
        chk(xfer_src_o == es, "R4/R5/R12 source address", xfer_src_o, es);
        chk(xfer_dst_o == ed, "R4/R5/R12 destination address", xfer_dst_o, ed);
        chk(xfer_size_o == 5'(st), "R12 size unchanged", 32'(xfer_size_o), 32'(st));
      end
      acc = xfer_valid_o && xfer_ready_i;
      if (acc) begin
        es = next_addr(es, c[14], c[12], st);
        ed = next_addr(ed, c[13], c[11], st);
        n_left--;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (n_left > 0) chk(done_o == 1'b0, "R11 no early done", 32'(done_o), 0);
    end
    xfer_ready_i = 1'b0; preq_i = 1'b0;
    #1;
    chk(done_o == 1'b1, "R11 done after last transfer", 32'(done_o), 1);
    chk(busy_o == 1'b0, "R11 idle after last transfer", 32'(busy_o), 0);
    @(negedge clk);
    #1;
    chk(done_o == 1'b0, "R11 done lasts one cycle", 32'(done_o), 0);
  endtask

  function automatic logic [31:0] rand_cfg();
    logic [31:0] c;
    int u;
    c = $urandom;                      // R8 ignored bits left random
    u = $urandom % 3;
    c[9:8] = 2'(u);
    c[10]  = (u == 2) && (($urandom % 2) == 1);
    c[7:6] = 2'($urandom % 3);
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] c, s, d;
    int st;
    void'($urandom(32'h5EED_0011));
    rst_n = 1'b0; start_i = 1'b0; cfg_i = '0; src_i = '0; dst_i = '0; len_i = '0;
    preq_i = 1'b0; xfer_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy_o == 0 && done_o == 0 && err_o == 0 && xfer_valid_o == 0,
        "R11 reset state", {busy_o, done_o, err_o, xfer_valid_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reserved direction
    run_job(32'h0000_00C0, 32'h100, 32'h200, 16'd4, 100, 100);
    // R2 reserved unit
    run_job(32'h0000_0300, 32'h100, 32'h200, 16'd4, 100, 100);
    // R3 block bit with 16-bit unit
    run_job(32'h0000_0500, 32'h100, 32'h200, 16'd32, 100, 100);
    // R3 block bit, 4-byte aligned but not 16
    run_job(32'h0000_0600, 32'h104, 32'h200, 16'd32, 100, 100);
    // R6 misaligned destination, 16-bit unit
    run_job(32'h0000_0100, 32'h100, 32'h201, 16'd4, 100, 100);
    // R7 zero count and non-multiple count
    run_job(32'h0000_0200, 32'h100, 32'h200, 16'd0, 100, 100);
    run_job(32'h0000_0200, 32'h100, 32'h200, 16'd6, 100, 100);
    // R8 err cleared by accepted start; ignored bits all set
    run_job(32'hFFFF_803F & 32'hFFFF_80FF | 32'h0000_0000, 32'h40, 32'h80, 16'd3, 100, 0);
    // R3 block mode, R4 decrement wraps below zero, R5 hold over decrement
    run_job(32'h0000_1600 | 32'h0000_6800, 32'h0, 32'h0, 16'd48, 70, 100);
    run_job(32'h0000_1E00, 32'h0, 32'h10, 16'd48, 100, 100);
    // R9 peripheral to memory with sparse requests
    run_job(32'h0000_0080, 32'h1000, 32'h2000, 16'd5, 100, 30);
    // R10 m2m with requests low, ready always high
    run_job(32'h0000_0200, 32'h1000, 32'h2000, 16'd16, 100, 0);

    for (int j = 0; j < 60; j++) begin
      c  = rand_cfg();
      st = step_of(c);
      s  = $urandom & ~(32'(st) - 1);
      d  = $urandom & ~(32'(st) - 1);
      if (($urandom % 8) == 0) s = s | 32'(1);
      run_job(c, s, d, 16'(st * (1 + ($urandom % 6))), 20 + ($urandom % 81), 20 + ($urandom % 81));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule